// File: doc/BRIEF.md
# Pulse-Width Single-Wire Slave Port

This block is the slave end of a one-wire serial link. The wire is open-drain with a pull-up, so either side can only pull it low. Each bit takes a fixed time slot. A slot opens with a low pulse, and the length of that pulse carries the bit value. The block never starts traffic. It waits for the host to hold the wire low for a long stretch (a break). When the host lets the wire rise again, the block reads one command byte. The low seven bits of that byte select a register, and the top bit selects the direction. For a write, the host then sends one more byte. For a read, the block pulls the wire itself to return one byte.

Every timing value is a parameter counted in system clock cycles. These are the break threshold, the pulse width that separates a 1 from a 0, the slot length, the two widths the slave drives, and the pause before the slave starts to answer. The register side is a plain strobe interface: an address, a write strobe with data, and a read strobe whose data must be valid by the first driven bit.

Top module: `pwl_slave`

## Requirements
- R1: While reset is asserted and after it is released, the drive output is low and neither the write nor the read strobe is raised until a full transaction has been received.
- R2: A transaction begins only after the wire has been low for at least BREAK_MIN consecutive cycles. Pulses seen before the first such break, and lows shorter than BREAK_MIN while idle, cause no strobe and no drive.
- R3: A host pulse shorter than SAMPLE_AT cycles is read as 1. A pulse of SAMPLE_AT cycles up to BREAK_MIN-1 cycles is read as 0. Bits build each byte from bit 0 upward.
- R4: In the command byte, bits 6..0 give the register address and bit 7 picks the direction: 1 means the host writes, 0 means the host reads. The write and read strobes are never high together.
- R5: After the eighth data bit of a write, wr_en_o is high for exactly one cycle, with addr_o and wr_data_o holding the received values. That cycle is the one after the wire rises at the end of that bit's pulse.
- R6: After the eighth bit of a read command, rd_en_o is high for exactly one cycle with addr_o valid. That cycle is the one after the wire rises at the end of that bit's pulse.
- R7: TURN_CYC cycles after the read strobe, the slave drives eight slots of SLOT_LEN cycles each, bit 0 first. Each slot opens with a low of TX_W1 cycles for a 1 or TX_W0 cycles for a 0, then releases the wire. The byte sent is the value on rd_data_i when the first slot starts.
- R8: Once the single data byte of a transaction is done, further pulses without a new break produce no strobe. There is no address increment.
- R9: A low of BREAK_MIN cycles at any point aborts the current transaction. A partly received write byte is dropped with no strobe, any drive in progress stops the next cycle, and a new command is expected.
- R10: Boundary widths are decoded exactly. SAMPLE_AT-1 cycles gives a 1, SAMPLE_AT cycles gives a 0, BREAK_MIN-1 cycles gives a 0, and a low of exactly BREAK_MIN cycles counts as a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Wire level, already synchronized to clk_i |
| oe_o | output | 1 | High pulls the wire low |
| addr_o | output | DATA_W-1 | Register address from the last command |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | DATA_W | Byte received for a write |
| rd_en_o | output | 1 | One-cycle read request |
| rd_data_i | input | DATA_W | Read data, valid from the read request until the first slot starts |

## Verification
The host model changes the wire on falling clock edges and notes the cycle count at each release. Both strobes must appear exactly one cycle after the release that ends the last bit, and the bench compares the recorded cycle numbers to that count. The first slave pulse must begin exactly TURN_CYC cycles after the read strobe. Each driven pulse is measured in whole cycles and must equal TX_W1 or TX_W0, and consecutive pulse starts must be SLOT_LEN apart. All samples are taken on falling edges, half a cycle after the registers update.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BRK,
      ST_CMD,
      ST_WDATA,
      ST_TURN,
      ST_TX
   } pwl_state_e;
endpackage

// File: rtl/pwl_pulse_meter.sv
module pwl_pulse_meter #(
   parameter int unsigned BREAK_MIN = 48
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             line_i,
   output logic                             rise_o,
   output logic                             brk_o,
   output logic [$clog2(BREAK_MIN+1)-1:0]   width_o
);
   localparam int unsigned CW = $clog2(BREAK_MIN + 1);

   logic          line_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_q <= 1'b1;
         cnt_q  <= '0;
      end else begin
         line_q <= line_i;
         if (line_i) begin
            cnt_q <= '0;
         end else if (cnt_q != CW'(BREAK_MIN)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // cnt_q holds the number of low samples before the current one
   assign rise_o  = line_i & ~line_q;
   assign brk_o   = ~line_i & (cnt_q == CW'(BREAK_MIN - 1));
   assign width_o = cnt_q;
endmodule

// File: rtl/pwl_byte_rx.sv
module pwl_byte_rx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              last_o
);
   localparam int unsigned IW = $clog2(DATA_W);

   logic [IW-1:0]     idx_q;
   logic [DATA_W-1:0] sh_q;

   // first bit received ends up in bit 0
   assign byte_o = {bit_i, sh_q[DATA_W-1:1]};
   assign last_o = bit_vld_i && (idx_q == IW'(DATA_W - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q <= '0;
         sh_q  <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (bit_vld_i) begin
         sh_q  <= byte_o;
         idx_q <= last_o ? '0 : idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwl_tx_engine.sv
module pwl_tx_engine #(
   parameter int unsigned SLOT_LEN = 40,
   parameter int unsigned W_ONE    = 8,
   parameter int unsigned W_ZERO   = 24,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              drive_o,
   output logic              busy_o
);
   localparam int unsigned SW = $clog2(SLOT_LEN);
   localparam int unsigned IW = $clog2(DATA_W);

   logic [SW-1:0]     slot_q;
   logic [IW-1:0]     idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              busy_q;
   logic              slot_end;
   logic              last_bit;
   logic [SW-1:0]     low_len;

   assign slot_end = slot_q == SW'(SLOT_LEN - 1);
   assign last_bit = idx_q == IW'(DATA_W - 1);
   assign low_len  = sh_q[0] ? SW'(W_ONE) : SW'(W_ZERO);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         slot_q <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         slot_q <= '0;
         idx_q  <= '0;
         sh_q   <= data_i;
      end else if (busy_q) begin
         if (slot_end) begin
            slot_q <= '0;
            sh_q   <= sh_q >> 1;
            idx_q  <= idx_q + 1'b1;
            if (last_bit) busy_q <= 1'b0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign drive_o = busy_q && (slot_q < low_len);
   assign busy_o  = busy_q;
endmodule

// File: rtl/pwl_slave.sv
module pwl_slave #(
   parameter int unsigned BREAK_MIN = 48,
   parameter int unsigned SAMPLE_AT = 14,
   parameter int unsigned SLOT_LEN  = 40,
   parameter int unsigned TX_W1     = 8,
   parameter int unsigned TX_W0     = 24,
   parameter int unsigned TURN_CYC  = 16,
   parameter int unsigned DATA_W    = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_i,
   output logic              oe_o,
   output logic [DATA_W-2:0] addr_o,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              rd_en_o,
   input  logic [DATA_W-1:0] rd_data_i
);
   import pwl_pkg::*;

   localparam int unsigned ADDR_W = DATA_W - 1;
   localparam int unsigned MW     = $clog2(BREAK_MIN + 1);
   localparam int unsigned TW     = $clog2(TURN_CYC + 1);

   // elaboration checks on the timing parameters
   if (TX_W1 == 0 || TX_W1 >= SAMPLE_AT) begin : g_bad_w1
      $error("TX_W1 must be nonzero and below SAMPLE_AT");
   end
   if (TX_W0 < SAMPLE_AT || TX_W0 >= SLOT_LEN) begin : g_bad_w0
      $error("TX_W0 must lie in [SAMPLE_AT, SLOT_LEN)");
   end
   if (SAMPLE_AT >= BREAK_MIN || TX_W0 >= BREAK_MIN) begin : g_bad_brk
      $error("BREAK_MIN must exceed SAMPLE_AT and TX_W0");
   end
   if (TURN_CYC == 0) begin : g_bad_turn
      $error("TURN_CYC must be at least one");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("DATA_W must be 8");
   end

   pwl_state_e        state_q;
   logic              rise;
   logic              brk_evt;
   logic [MW-1:0]     low_w;
   logic              bit_vld;
   logic              bit_val;
   logic [DATA_W-1:0] rx_byte;
   logic              rx_last;
   logic              tx_start;
   logic              tx_drive;
   logic              tx_busy;
   logic [TW-1:0]     tcnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q;
   logic              rd_q;

   pwl_pulse_meter #(.BREAK_MIN(BREAK_MIN)) u_meter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_i),
      .rise_o  (rise),
      .brk_o   (brk_evt),
      .width_o (low_w)
   );

   assign bit_vld = rise && ((state_q == ST_CMD) || (state_q == ST_WDATA));
   assign bit_val = low_w < MW'(SAMPLE_AT);

   pwl_byte_rx #(.DATA_W(DATA_W)) u_rx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (state_q == ST_BRK),
      .bit_vld_i (bit_vld),
      .bit_i     (bit_val),
      .byte_o    (rx_byte),
      .last_o    (rx_last)
   );

   assign tx_start = (state_q == ST_TURN) && (tcnt_q == TW'(TURN_CYC - 1)) && !brk_evt;

   pwl_tx_engine #(
      .SLOT_LEN (SLOT_LEN),
      .W_ONE    (TX_W1),
      .W_ZERO   (TX_W0),
      .DATA_W   (DATA_W)
   ) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (tx_start),
      .abort_i (brk_evt),
      .data_i  (rd_data_i),
      .drive_o (tx_drive),
      .busy_o  (tx_busy)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         tcnt_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         if (brk_evt) begin
            state_q <= ST_BRK;
         end else begin
            unique case (state_q)
               ST_IDLE: ;
               ST_BRK: if (rise) state_q <= ST_CMD;
               ST_CMD: if (rx_last) begin
                  addr_q <= rx_byte[ADDR_W-1:0];
                  if (rx_byte[DATA_W-1]) begin
                     state_q <= ST_WDATA;
                  end else begin
                     state_q <= ST_TURN;
                     rd_q    <= 1'b1;
                     tcnt_q  <= '0;
                  end
               end
               ST_WDATA: if (rx_last) begin
                  wdata_q <= rx_byte;
                  wr_q    <= 1'b1;
                  state_q <= ST_IDLE;
               end
               ST_TURN: begin
                  tcnt_q <= tcnt_q + 1'b1;
                  if (tx_start) state_q <= ST_TX;
               end
               ST_TX: if (!tx_busy) state_q <= ST_IDLE;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign oe_o      = tx_drive;
   assign addr_o    = addr_q;
   assign wr_en_o   = wr_q;
   assign wr_data_o = wdata_q;
   assign rd_en_o   = rd_q;
endmodule

// File: rtl/pwl_slave_chk.sv
module pwl_slave_chk #(
   parameter int unsigned TX_W0 = 24
) (
   input logic clk_i,
   input logic rst_ni,
   input logic line_i,
   input logic oe_o,
   input logic wr_en_o,
   input logic rd_en_o,
   input logic brk_evt
);
   localparam int unsigned RW = $clog2(TX_W0 + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (oe_o) begin
         if (run_q != RW'(TX_W0 + 1)) run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_o && rd_en_o));

   p_wr_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |=> !wr_en_o);

   p_rd_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_o |=> !rd_en_o);

   p_drive_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RW'(TX_W0));

   p_line_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_o |-> !line_i);

   p_break_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_evt |=> !oe_o);
endmodule

bind pwl_slave pwl_slave_chk #(.TX_W0(TX_W0)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .line_i  (line_i),
   .oe_o    (oe_o),
   .wr_en_o (wr_en_o),
   .rd_en_o (rd_en_o),
   .brk_evt (brk_evt)
);

// File: tb/tb_pwl_slave.sv
module tb_pwl_slave;
   localparam int CLK_P = 10;
   localparam int BRK   = 48;
   localparam int SMP   = 14;
   localparam int SLOT  = 40;
   localparam int W1    = 8;
   localparam int W0    = 24;
   localparam int TURN  = 16;
   localparam int H1    = 6;
   localparam int H0    = 24;
   localparam int HSLOT = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_pull = 1'b0;
   wire        line;
   logic       oe;
   logic [6:0] addr;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       rd_en;
   logic [7:0] rd_data;

   function automatic logic [7:0] rd_model(input logic [6:0] a);
      return ({1'b0, a} * 8'd29) ^ 8'h5A;
   endfunction

   assign line    = ~(host_pull | oe);
   assign rd_data = rd_model(addr);

   pwl_slave dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .line_i    (line),
      .oe_o      (oe),
      .addr_o    (addr),
      .wr_en_o   (wr_en),
      .wr_data_o (wr_data),
      .rd_en_o   (rd_en),
      .rd_data_i (rd_data)
   );

   always #(CLK_P/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [6:0] wr_a_q[$];
   logic [7:0] wr_d_q[$];
   int         wr_c_q[$];
   logic [6:0] rd_a_q[$];
   int         rd_c_q[$];
   int         oe_w_q[$];
   int         oe_f_q[$];
   bit         oe_prev = 1'b0;
   int         oe_run = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            wr_a_q.push_back(addr);
            wr_d_q.push_back(wr_data);
            wr_c_q.push_back(cyc);
         end
         if (rd_en) begin
            rd_a_q.push_back(addr);
            rd_c_q.push_back(cyc);
         end
         if (oe && !oe_prev) begin
            oe_f_q.push_back(cyc);
            oe_run = 0;
         end
         if (oe) oe_run++;
         if (!oe && oe_prev) oe_w_q.push_back(oe_run);
         oe_prev = oe;
      end
   end

   int n_tests = 0;
   int n_fail  = 0;
   int rel_cyc = 0;

   task automatic check(string req, int act, int exp, string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_q();
      wr_a_q.delete(); wr_d_q.delete(); wr_c_q.delete();
      rd_a_q.delete(); rd_c_q.delete();
      oe_w_q.delete(); oe_f_q.delete();
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_low(int n);
      host_pull = 1'b1;
      repeat (n) @(negedge clk);
      host_pull = 1'b0;
      rel_cyc = cyc;
   endtask

   task automatic host_break(int n);
      host_low(n);
      idle(15);
   endtask

   task automatic send_bit(bit v, int w1, int w0);
      int w;
      w = v ? w1 : w0;
      host_low(w);
      idle((HSLOT - w > 8) ? HSLOT - w : 8);
   endtask

   task automatic send_byte(logic [7:0] b, int w1, int w0);
      for (int i = 0; i < 8; i++) send_bit(b[i], w1, w0);
   endtask

   task automatic do_write(logic [6:0] a, logic [7:0] d, int w1, int w0, int bw);
      int rel;
      clear_q();
      host_break(bw);
      send_byte({1'b1, a}, w1, w0);
      send_byte(d, w1, w0);
      rel = rel_cyc;
      idle(4);
      check("R5", wr_a_q.size(), 1, "write strobe count");
      check("R6", rd_a_q.size(), 0, "no read strobe on write");
      if (wr_a_q.size() == 1) begin
         check("R4", int'(wr_a_q[0]), int'(a), "write address");
         check("R3", int'(wr_d_q[0]), int'(d), "write data");
         check("R5", wr_c_q[0], rel + 1, "write strobe cycle");
      end
   endtask

   task automatic do_read(logic [6:0] a, int w1, int w0, int bw);
      int rel;
      int t;
      logic [7:0] exp;
      clear_q();
      exp = rd_model(a);
      host_break(bw);
      send_byte({1'b0, a}, w1, w0);
      rel = rel_cyc;
      t = 0;
      while (oe_w_q.size() < 8 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check("R6", rd_a_q.size(), 1, "read strobe count");
      check("R4", wr_a_q.size(), 0, "no write strobe on read");
      check("R7", oe_w_q.size(), 8, "driven pulse count");
      if (rd_a_q.size() == 1) begin
         check("R4", int'(rd_a_q[0]), int'(a), "read address");
         check("R6", rd_c_q[0], rel + 1, "read strobe cycle");
         if (oe_f_q.size() > 0)
            check("R7", oe_f_q[0], rd_c_q[0] + TURN, "turnaround");
      end
      if (oe_w_q.size() >= 8) begin
         for (int i = 0; i < 8; i++)
            check("R7", oe_w_q[i], exp[i] ? W1 : W0, "drive width");
         for (int i = 1; i < 8; i++)
            check("R7", oe_f_q[i] - oe_f_q[i-1], SLOT, "slot spacing");
      end
      idle(SLOT);
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      void'($urandom(32'h0000C0DE));
      idle(3);
      // R1: reset state
      check("R1", int'(oe), 0, "drive in reset");
      check("R1", int'(wr_en), 0, "write strobe in reset");
      check("R1", int'(rd_en), 0, "read strobe in reset");
      rst_n = 1'b1;
      idle(20);
      check("R1", int'(oe), 0, "drive after reset");

      // R2: traffic before any break, and a near-break low, is ignored
      clear_q();
      send_byte(8'h85, H1, H0);
      host_low(BRK - 1);
      idle(10);
      send_byte(8'h3C, H1, H0);
      idle(TURN + 8 * SLOT);
      check("R2", wr_a_q.size() + rd_a_q.size(), 0, "strobes without break");
      check("R2", oe_f_q.size(), 0, "drive without break");

      // directed write and read
      do_write(7'h15, 8'hA3, H1, H0, BRK + 10);
      do_read(7'h33, H1, H0, BRK + 10);

      // R10: boundary widths and exact break length
      do_write(7'h6A, 8'h55, SMP - 1, SMP, BRK);
      do_write(7'h01, 8'hF0, SMP - 1, BRK - 1, BRK);
      do_read(7'h7F, SMP - 1, SMP, BRK);

      // R8: one byte per transaction
      do_write(7'h22, 8'h99, H1, H0, BRK + 3);
      clear_q();
      send_byte(8'hFF, H1, H0);
      send_byte(8'h12, H1, H0);
      idle(TURN + 8 * SLOT);
      check("R8", wr_a_q.size() + rd_a_q.size(), 0, "strobes after byte done");
      check("R8", oe_f_q.size(), 0, "drive after byte done");

      // R9: break aborts a partial write
      clear_q();
      host_break(BRK + 2);
      send_byte({1'b1, 7'h44}, H1, H0);
      for (int i = 0; i < 4; i++) send_bit(1'b1, H1, H0);
      host_break(BRK + 2);
      send_byte({1'b1, 7'h45}, H1, H0);
      send_byte(8'h6C, H1, H0);
      idle(4);
      check("R9", wr_a_q.size(), 1, "strobes after aborted write");
      if (wr_a_q.size() == 1) begin
         check("R9", int'(wr_a_q[0]), 8'h45, "address after abort");
         check("R9", int'(wr_d_q[0]), 8'h6C, "data after abort");
      end

      // R9: break during slave drive
      clear_q();
      host_break(BRK + 2);
      send_byte({1'b0, 7'h10}, H1, H0);
      while (oe_f_q.size() < 3) @(negedge clk);
      host_low(BRK + 4);
      check("R9", int'(oe), 0, "drive released by break");
      clear_q();
      idle(TURN + 8 * SLOT);
      check("R9", oe_f_q.size(), 0, "no drive after aborted read");
      do_write(7'h0E, 8'h3B, H1, H0, BRK + 5);

      // random mix
      for (int k = 0; k < 16; k++) begin
         logic [6:0] a;
         logic [7:0] d;
         int w1, w0, bw;
         a  = 7'($urandom_range(0, 127));
         d  = 8'($urandom_range(0, 255));
         w1 = $urandom_range(2, SMP - 1);
         w0 = $urandom_range(SMP, BRK - 1);
         bw = $urandom_range(BRK, BRK + 20);
         if ($urandom_range(0, 1) == 1) do_write(a, d, w1, w0, bw);
         else                           do_read(a, w1, w0, bw);
      end

      report();
   end
endmodule